// File: doc/BRIEF.md
# Voltage-Level Grouping Converter Allocator

Once per power-management control cycle this block receives, for every core, a demanded supply level and a subgroup label from an upstream clustering stage. It sorts the cores into one group per supply level. Converters serve a group only at that group's level, and they are time-shared across the subgroups of that group. The converter count for a group is therefore set by its largest subgroup, not by the number of cores in the group. The count is that size divided by the driving capacity of one converter at that level, rounded up.

A start pulse latches all inputs. The block then walks the cores one per cycle and raises a one-cycle done pulse. With the pulse it presents the per-group converter counts, their total, and for each core its group and the index of the converter it uses inside that group. A switch network downstream uses these per-core values. The latency is fixed and depends only on the core count.

Top module: `conv_alloc`

## Requirements
- R1: After reset, done_o is low and every count, total, group and converter output is zero.
- R2: When start_i is high at a rising edge while the block is idle, level_i and subgrp_i are latched. done_o is then high for exactly one cycle, namely the cycle after the (N_CORES+1)-th following rising edge.
- R3: A start_i pulse that arrives while a job is in progress has no effect on the results or on the timing of that job.
- R4: Level codes are 0, 1, 2 and 3 for 0.6 V, 0.8 V, 1.0 V and 1.2 V. Core i's code is level_i[2i+1:2i]. core_grp_o for core i (bits [2i+1:2i]) equals its demanded code, so the supplied level is never below the demand.
- R5: One converter drives at most 4, 3, 2 and 1 cores at codes 0, 1, 2 and 3. The count for group g (grp_cnt_o[g*CNT_W +: CNT_W]) equals ceil(largest subgroup size in g / capacity of g). Subgroup labels (subgrp_i[2i+1:2i]) are counted separately in each group.
- R6: A group with no cores is given zero converters.
- R7: total_o equals the sum of the four group counts.
- R8: Within a subgroup, cores are taken in ascending core index. The j-th such core (from 0) is given converter floor(j / capacity) of its group (core_conv_o[i*CONV_W +: CONV_W]). Every assigned index is therefore below the group's count.
- R9: All result outputs hold their values from one done pulse until the next, whatever the inputs do in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Latch inputs and begin a job |
| level_i | input | N_CORES*2 | Demanded level code per core |
| subgrp_i | input | N_CORES*SG_W | Subgroup label per core |
| done_o | output | 1 | One-cycle pulse when results are valid |
| grp_cnt_o | output | 4*CNT_W | Converter count per level group |
| total_o | output | CNT_W | Sum of group counts |
| core_grp_o | output | N_CORES*2 | Group (level code) given to each core |
| core_conv_o | output | N_CORES*CONV_W | Converter index of each core within its group |

## Verification
The checker assumes that start_i is a clean synchronous level. It also assumes that level_i and subgrp_i hold every core's code inside the field widths, so any bit pattern is a legal demand. Its latency property tracks accepted starts on its own and ignores starts that fall inside a job. The stimulus drives every input at the falling edge. It covers the saturated case with every core in one group and subgroup, groups that are absent, and subgroup sizes just above and just below a capacity. It also issues a second start in the middle of a job with different data, and it changes the inputs without a start between jobs.

// File: rtl/conv_alloc_pkg.sv
package conv_alloc_pkg;
  localparam int unsigned NUM_LVL = 4;
  localparam int unsigned LVL_W   = 2;

  // cores one converter can drive at a level code
  function automatic int unsigned drive_cap(int unsigned lvl);
    return NUM_LVL - lvl;
  endfunction

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_FIN} st_e;
endpackage

// File: rtl/alloc_ctrl.sv
module alloc_ctrl
  import conv_alloc_pkg::*;
#(
  parameter int unsigned N_CORES = 8,
  parameter int unsigned IDX_W   = $clog2(N_CORES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             latch_o,
  output logic             scan_o,
  output logic             fin_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);
  st_e              st_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;

  assign latch_o = start_i && (st_q == ST_IDLE);
  assign scan_o  = (st_q == ST_SCAN);
  assign fin_o   = (st_q == ST_FIN);
  assign idx_o   = idx_q;
  assign done_o  = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= (st_q == ST_FIN);
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_SCAN;
          idx_q <= '0;
        end
        ST_SCAN: begin
          if (idx_q == IDX_W'(N_CORES - 1)) st_q <= ST_FIN;
          else idx_q <= idx_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lvl_tally.sv
module lvl_tally
  import conv_alloc_pkg::*;
#(
  parameter int unsigned LVL    = 0,
  parameter int unsigned SG_W   = 2,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned CONV_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              hit_i,
  input  logic [SG_W-1:0]   sg_i,
  output logic [CONV_W-1:0] conv_o,
  output logic [CNT_W-1:0]  need_o
);
  localparam int unsigned CAP    = drive_cap(LVL);
  localparam int unsigned N_SG   = 1 << SG_W;
  localparam int unsigned SLOT_W = 3;

  logic [CNT_W-1:0]  conv_q [N_SG];
  logic [SLOT_W-1:0] slot_q [N_SG];

  for (genvar s = 0; s < N_SG; s++) begin : g_sg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        conv_q[s] <= '0;
        slot_q[s] <= '0;
      end else if (clr_i) begin
        conv_q[s] <= '0;
        slot_q[s] <= '0;
      end else if (hit_i && sg_i == SG_W'(s)) begin
        if (slot_q[s] == SLOT_W'(CAP - 1)) begin
          slot_q[s] <= '0;
          conv_q[s] <= conv_q[s] + 1'b1;
        end else begin
          slot_q[s] <= slot_q[s] + 1'b1;
        end
      end
    end
  end

  logic [CNT_W-1:0] cur_conv;
  assign cur_conv = conv_q[sg_i];
  assign conv_o   = cur_conv[CONV_W-1:0];

  // converters in use by the largest subgroup, partial converter rounds up
  always_comb begin
    need_o = '0;
    for (int s = 0; s < N_SG; s++) begin
      if (conv_q[s] + CNT_W'(slot_q[s] != '0) > need_o)
        need_o = conv_q[s] + CNT_W'(slot_q[s] != '0);
    end
  end
endmodule

// File: rtl/conv_alloc.sv
module conv_alloc
  import conv_alloc_pkg::*;
#(
  parameter int unsigned N_CORES = 8,
  parameter int unsigned SG_W    = 2,
  localparam int unsigned CNT_W  = $clog2(N_CORES + 1),
  localparam int unsigned CONV_W = $clog2(N_CORES),
  localparam int unsigned IDX_W  = $clog2(N_CORES)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [N_CORES*LVL_W-1:0]    level_i,
  input  logic [N_CORES*SG_W-1:0]     subgrp_i,
  output logic                        done_o,
  output logic [NUM_LVL*CNT_W-1:0]    grp_cnt_o,
  output logic [CNT_W-1:0]            total_o,
  output logic [N_CORES*LVL_W-1:0]    core_grp_o,
  output logic [N_CORES*CONV_W-1:0]   core_conv_o
);
  logic                       latch, scan, fin;
  logic [IDX_W-1:0]           idx;
  logic [N_CORES*LVL_W-1:0]   lvl_q;
  logic [N_CORES*SG_W-1:0]    sg_q;
  logic [N_CORES*CONV_W-1:0]  asg_q;
  logic [LVL_W-1:0]           cur_lvl;
  logic [SG_W-1:0]            cur_sg;
  logic [CONV_W-1:0]          conv_l [NUM_LVL];
  logic [CNT_W-1:0]           need_l [NUM_LVL];
  logic [CNT_W-1:0]           tot;

  alloc_ctrl #(.N_CORES(N_CORES), .IDX_W(IDX_W)) i_ctrl (
    .clk_i, .rst_ni, .start_i,
    .latch_o(latch), .scan_o(scan), .fin_o(fin), .idx_o(idx), .done_o
  );

  assign cur_lvl = lvl_q[idx*LVL_W +: LVL_W];
  assign cur_sg  = sg_q[idx*SG_W +: SG_W];

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    lvl_tally #(.LVL(l), .SG_W(SG_W), .CNT_W(CNT_W), .CONV_W(CONV_W)) i_tally (
      .clk_i, .rst_ni,
      .clr_i (latch),
      .hit_i (scan && cur_lvl == LVL_W'(l)),
      .sg_i  (cur_sg),
      .conv_o(conv_l[l]),
      .need_o(need_l[l])
    );
  end

  always_comb begin
    tot = '0;
    for (int l = 0; l < NUM_LVL; l++) tot = tot + need_l[l];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q       <= '0;
      sg_q        <= '0;
      asg_q       <= '0;
      grp_cnt_o   <= '0;
      total_o     <= '0;
      core_grp_o  <= '0;
      core_conv_o <= '0;
    end else begin
      if (latch) begin
        lvl_q <= level_i;
        sg_q  <= subgrp_i;
      end
      if (scan) asg_q[idx*CONV_W +: CONV_W] <= conv_l[cur_lvl];
      if (fin) begin
        for (int l = 0; l < NUM_LVL; l++) grp_cnt_o[l*CNT_W +: CNT_W] <= need_l[l];
        total_o     <= tot;
        core_grp_o  <= lvl_q;
        core_conv_o <= asg_q;
      end
    end
  end
endmodule

// File: rtl/conv_alloc_chk.sv
module conv_alloc_chk #(
  parameter int unsigned N_CORES = 8,
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned CONV_W  = 3
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      start_i,
  input logic                      done_o,
  input logic [4*CNT_W-1:0]        grp_cnt_o,
  input logic [CNT_W-1:0]          total_o,
  input logic [N_CORES*2-1:0]      core_grp_o,
  input logic [N_CORES*CONV_W-1:0] core_conv_o
);
  logic             busy_q;
  logic [CNT_W:0]   cnt_q;
  logic             conv_ok, empty_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && (!busy_q || done_o)) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    logic [3:0] used;
    conv_ok  = 1'b1;
    empty_ok = 1'b1;
    used     = '0;
    for (int i = 0; i < N_CORES; i++) begin
      used[core_grp_o[i*2 +: 2]] = 1'b1;
      if ({1'b0, core_conv_o[i*CONV_W +: CONV_W]} >=
          {1'b0, grp_cnt_o[core_grp_o[i*2 +: 2]*CNT_W +: CNT_W]})
        conv_ok = 1'b0;
    end
    for (int l = 0; l < 4; l++)
      if (!used[l] && grp_cnt_o[l*CNT_W +: CNT_W] != '0) empty_ok = 1'b0;
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R2 R3
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (busy_q && cnt_q == (CNT_W+1)'(N_CORES + 1)));
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(core_conv_o) && $stable(grp_cnt_o) && $stable(total_o) && $stable(core_grp_o)));
  // R8
  conv_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> conv_ok);
  // R6
  empty_grp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> empty_ok);
  // R7
  total_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ({1'b0, total_o} <= (CNT_W+1)'(N_CORES)));
endmodule

bind conv_alloc conv_alloc_chk #(.N_CORES(N_CORES), .CNT_W(CNT_W), .CONV_W(CONV_W)) i_chk (
  .clk_i, .rst_ni, .start_i, .done_o, .grp_cnt_o, .total_o, .core_grp_o, .core_conv_o
);

// File: tb/test_conv_alloc.sv
module test_conv_alloc;
  localparam int N    = 8;
  localparam int SW   = 2;
  localparam int CW   = $clog2(N + 1);
  localparam int VW   = $clog2(N);
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [4*CW-1:0] cnt;
    logic [CW-1:0]   tot;
    logic [N*2-1:0]  grp;
    logic [N*VW-1:0] conv;
    int              due;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [N*2-1:0]  level = '0;
  logic [N*SW-1:0] subgrp = '0;
  logic            done;
  logic [4*CW-1:0] grp_cnt;
  logic [CW-1:0]   total;
  logic [N*2-1:0]  core_grp;
  logic [N*VW-1:0] core_conv;

  int n_chk = 0, n_fail = 0, cyc = 0;
  exp_t q[$];
  exp_t last;
  bit   ended = 0;

  conv_alloc #(.N_CORES(N), .SG_W(SW)) i_conv_alloc (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .level_i(level), .subgrp_i(subgrp),
    .done_o(done), .grp_cnt_o(grp_cnt), .total_o(total),
    .core_grp_o(core_grp), .core_conv_o(core_conv)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic exp_t model(input logic [N*2-1:0] lv, input logic [N*SW-1:0] sg);
    exp_t e;
    int seen [4][4];
    int tot;
    e = '0;
    tot = 0;
    for (int l = 0; l < 4; l++) for (int s = 0; s < 4; s++) seen[l][s] = 0;
    for (int i = 0; i < N; i++) begin
      int l, s;
      l = int'(lv[i*2 +: 2]);
      s = int'(sg[i*SW +: SW]);
      e.conv[i*VW +: VW] = VW'(seen[l][s] / (4 - l));
      seen[l][s]++;
    end
    for (int l = 0; l < 4; l++) begin
      int mx, g;
      mx = 0;
      for (int s = 0; s < 4; s++) if (seen[l][s] > mx) mx = seen[l][s];
      g = (mx + 3 - l) / (4 - l);
      e.cnt[l*CW +: CW] = CW'(g);
      tot += g;
    end
    e.tot = CW'(tot);
    e.grp = lv;
    return e;
  endfunction

  task automatic run_job(input logic [N*2-1:0] lv, input logic [N*SW-1:0] sg, input bit dbl);
    exp_t e;
    @(negedge clk);
    e = model(lv, sg);
    e.due = cyc + N + 2;
    q.push_back(e);
    last = e;
    level = lv; subgrp = sg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (dbl) begin
      // R3: second start mid-job with different data
      repeat (3) @(negedge clk);
      level = ~lv; subgrp = ~sg; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (q.size() == 0) begin
          chk("R3 unexpected done", 64'(done), 64'(0));
        end else begin
          exp_t e;
          e = q.pop_front();
          chk("R2 done latency", 64'(cyc), 64'(e.due));
          for (int l = 0; l < 4; l++)
            chk("R5 R6 group count", 64'(grp_cnt[l*CW +: CW]), 64'(e.cnt[l*CW +: CW]));
          chk("R7 total", 64'(total), 64'(e.tot));
          chk("R4 core group", 64'(core_grp), 64'(e.grp));
          chk("R8 converter assignment", 64'(core_conv), 64'(e.conv));
          @(negedge clk);
          chk("R2 done single cycle", 64'(done), 64'(0));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk("watchdog expired", 64'(1), 64'(0));
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 done", 64'(done), 64'(0));
    chk("R1 counts", 64'(grp_cnt), 64'(0));
    chk("R1 total", 64'(total), 64'(0));
    chk("R1 assignments", 64'({core_grp, core_conv}), 64'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_job(16'h0000, 16'h0000, 0);  // all 0.6 V, one subgroup
    run_job(16'hFFFF, 16'h4444, 0);  // all 1.2 V, two subgroups
    run_job(16'hE4E4, 16'h0000, 0);  // every level present
    run_job(16'h5555, 16'h9500, 0);  // 0.8 V, subgroups of 4/3/1
    run_job(16'h002A, 16'h0024, 0);  // 1.0 V in three singles, rest 0.6 V
    run_job(16'h1B1B, 16'h3C5A, 1);  // R3 busy restart ignored

    // R9: inputs move without start, results must hold
    level = 16'hAAAA; subgrp = 16'hFFFF;
    repeat (5) @(negedge clk);
    chk("R9 hold counts", 64'(grp_cnt), 64'(last.cnt));
    chk("R9 hold total", 64'(total), 64'(last.tot));
    chk("R9 hold assignment", 64'({core_grp, core_conv}), 64'({last.grp, last.conv}));
    chk("R9 no done", 64'(done), 64'(0));

    run_job(16'hAAAA, 16'h00FF, 0);  // back-to-back reuse after hold
    finish_run();
  end
endmodule